// File: doc/BRIEF.md
# Clock-Parking Standby Detector

This block lets a power-gated domain derive its own power-switch enable from nothing but its local clock, so no dedicated sleep net has to be routed to each switch. A free-running reference clock measures how long the domain clock has stayed high. While the domain clock keeps toggling, each high phase is short and the measurement is cleared before it reaches its limit. The block therefore holds the switch enable in its powered level. When the clock source parks the domain clock at logic high for longer than a parameterised limit, the block declares standby and drops the enable.

Wake-up is asymmetric on purpose. Entering standby is slow because it waits for the duration limit. Leaving standby depends only on the first low level of the domain clock seen through the synchronizer: the counter is not involved, and the block returns to the powered level within three reference cycles. A one-cycle `wake_pulse` tells a power-sequencing controller about every standby-to-active transition.

The limit `HIGH_LIMIT` must be larger than the longest legal high phase `LEGAL_HIGH_MAX`, including worst-case duty cycle. Elaboration fails if it is not.

Top module: `clkpark_detect`

## Requirements
- R1: During and right after a synchronous reset (`rst` high), `power_en` is 1, `standby` is 0 and `wake_pulse` is 0.
- R2: While every high phase of `dom_clk` lasts at most `HIGH_LIMIT` reference cycles, `standby` stays 0, whatever the duty cycle or the length of the low phases.
- R3: If `dom_clk` goes high before reference edge c+1 and stays high, `standby` rises at reference edge c+`HIGH_LIMIT`+3. That figure is two synchronizer stages plus `HIGH_LIMIT`+1 high samples, and it holds whenever the high phase lasts at least `HIGH_LIMIT`+1 cycles.
- R4: Once in standby, `standby` stays 1 for as long as `dom_clk` stays high, however long that is; no further transition occurs.
- R5: In standby, a low level of `dom_clk` that starts before reference edge d+1 clears `standby` at reference edge d+3. A low level of a single reference cycle is enough.
- R6: `wake_pulse` is 1 for exactly one reference cycle, in the cycle in which `standby` falls, and is 0 at every other time.
- R7: `power_en` is always the complement of `standby` (1 = domain powered).
- R8: Any sampled low level of `dom_clk` restarts the duration measurement. Two high phases of `HIGH_LIMIT` cycles each, separated by a single low cycle, do not cause standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock that times the high phase |
| rst | input | 1 | Synchronous active-high reset |
| dom_clk | input | 1 | Gated domain clock, asynchronous to `ref_clk` |
| power_en | output | 1 | Power-switch enable, 1 while the domain is active |
| standby | output | 1 | 1 while the domain clock is parked high |
| wake_pulse | output | 1 | One-cycle pulse on each standby-to-active transition |

## Verification
The domain clock is driven with a balanced toggle pattern and with a heavily skewed duty cycle whose high phase is exactly at the limit. These show that legal clocking never produces a standby, down to the last cycle of margin. A park of one cycle more than the limit and a park several times the limit separate the exact entry edge from a retriggering or a non-saturating counter. Single-cycle low levels, both in standby and between two limit-long high phases, show that wake-up bypasses the counter and that any low restarts the measurement.

// File: rtl/clkpark_pkg.sv
package clkpark_pkg;
  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_PARK = 1'b1
  } mode_e;
endpackage

// File: rtl/clkpark_sync.sv
module clkpark_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkpark_timer.sv
module clkpark_timer #(
  parameter int HIGH_LIMIT = 8,
  localparam int CNT_W = $clog2(HIGH_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic expire_o
);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(HIGH_LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // A sampled low clears the measure; a high counts up and saturates.
  always_comb begin
    if (!lvl_i)              cnt_d = '0;
    else if (cnt_q == LIM_V) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign expire_o = (cnt_q == LIM_V);

  assert_cnt_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM_V);

  // R8: a non-zero measure only follows a sampled high level
  assert_cnt_needs_high_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> $past(lvl_i));
endmodule

// File: rtl/clkpark_fsm.sv
module clkpark_fsm
  import clkpark_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic expire_i,
  output logic standby_o,
  output logic power_en_o,
  output logic wake_o
);
  mode_e mode_q, mode_d;
  logic  pen_q, wake_q;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN:  if (expire_i && lvl_i) mode_d = MODE_PARK;
      MODE_PARK: if (!lvl_i)            mode_d = MODE_RUN;
      default:                          mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_RUN;
      pen_q  <= 1'b1;
      wake_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pen_q  <= (mode_d == MODE_RUN);
      wake_q <= (mode_q == MODE_PARK) && (mode_d == MODE_RUN);
    end
  end

  assign standby_o  = (mode_q == MODE_PARK);
  assign power_en_o = pen_q;
  assign wake_o     = wake_q;

  assert_park_needs_expiry_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(standby_o) |-> $past(expire_i && lvl_i));

  assert_wake_needs_low_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(standby_o) |-> $past(!lvl_i));

  assert_wake_on_exit_R6: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> (!standby_o && $past(standby_o)));

  assert_wake_single_R6: assert property (@(posedge clk) disable iff (rst)
    wake_o |=> !wake_o);
endmodule

// File: rtl/clkpark_detect.sv
module clkpark_detect #(
  parameter int HIGH_LIMIT     = 8,
  parameter int LEGAL_HIGH_MAX = 6,
  parameter int SYNC_STAGES    = 2
) (
  input  logic ref_clk,
  input  logic rst,
  input  logic dom_clk,
  output logic power_en,
  output logic standby,
  output logic wake_pulse
);
  generate
    if (HIGH_LIMIT <= LEGAL_HIGH_MAX) begin : g_bad_limit
      $error("HIGH_LIMIT must exceed the longest legal high phase");
    end
  endgenerate

  logic lvl_s;
  logic expire_s;

  clkpark_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (ref_clk),
    .rst     (rst),
    .async_i (dom_clk),
    .sync_o  (lvl_s)
  );

  clkpark_timer #(.HIGH_LIMIT(HIGH_LIMIT)) u_timer (
    .clk      (ref_clk),
    .rst      (rst),
    .lvl_i    (lvl_s),
    .expire_o (expire_s)
  );

  clkpark_fsm u_fsm (
    .clk        (ref_clk),
    .rst        (rst),
    .lvl_i      (lvl_s),
    .expire_i   (expire_s),
    .standby_o  (standby),
    .power_en_o (power_en),
    .wake_o     (wake_pulse)
  );

  assert_enable_complement_R7: assert property (@(posedge ref_clk) disable iff (rst)
    power_en != standby);
endmodule

// File: tb/tb_clkpark_detect.sv
module tb_clkpark_detect;
  localparam int LIM = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dom = 1'b0;
  logic power_en, standby, wake_pulse;

  always #4 clk = ~clk;

  clkpark_detect #(.HIGH_LIMIT(LIM), .LEGAL_HIGH_MAX(6), .SYNC_STAGES(2)) dut (
    .ref_clk    (clk),
    .rst        (rst),
    .dom_clk    (dom),
    .power_en   (power_en),
    .standby    (standby),
    .wake_pulse (wake_pulse)
  );

  typedef struct {
    bit is_wake;
    int cyc;
  } ev_t;

  ev_t exp_q[$];
  int  cyc = 0;
  int  checks = 0;
  int  fails = 0;
  bit  mdl_park = 1'b0;
  bit  mon_on = 1'b0;
  bit  done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Drivers: change dom_clk at a falling ref edge and push expected events.
  task automatic hold_high(input int n);
    int c;
    dom = 1'b1;
    c = cyc;
    if (!mdl_park && n > LIM) begin
      exp_q.push_back('{1'b0, c + LIM + 3});
      mdl_park = 1'b1;
    end
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_low(input int m);
    int d;
    dom = 1'b0;
    d = cyc;
    if (mdl_park) begin
      exp_q.push_back('{1'b1, d + 3});
      mdl_park = 1'b0;
    end
    repeat (m) @(negedge clk);
  endtask

  // Monitor / scoreboard
  initial begin
    bit   prev_s, prev_w;
    ev_t  e;
    prev_s = 1'b0;
    prev_w = 1'b0;
    wait (mon_on);
    forever begin
      @(negedge clk);
      checks++;
      if (power_en !== ~standby) begin
        fails++;
        $display("FAIL R7 power_en=%b expected %b", power_en, ~standby);
      end
      if (standby !== prev_s) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R2/R8 unexpected standby=%b at cycle %0d, expected no change", standby, cyc);
        end else begin
          e = exp_q.pop_front();
          if (standby && (e.is_wake || e.cyc != cyc)) begin
            fails++;
            $display("FAIL R3 standby rise at cycle %0d wake=%0b, expected cycle %0d wake=%0b",
                     cyc, 1'b0, e.cyc, e.is_wake);
          end
          if (!standby && (!e.is_wake || e.cyc != cyc)) begin
            fails++;
            $display("FAIL R5 standby fall at cycle %0d wake=%0b, expected cycle %0d wake=%0b",
                     cyc, 1'b1, e.cyc, e.is_wake);
          end
          if (!standby) begin
            checks++;
            if (wake_pulse !== 1'b1) begin
              fails++;
              $display("FAIL R6 wake_pulse=%b at exit, expected 1", wake_pulse);
            end
          end
        end
      end else if (wake_pulse !== 1'b0) begin
        checks++;
        fails++;
        $display("FAIL R6 wake_pulse=%b without exit (prev %b), expected 0", wake_pulse, prev_w);
      end
      prev_s = standby;
      prev_w = wake_pulse;
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (power_en !== 1'b1 || standby !== 1'b0 || wake_pulse !== 1'b0) begin
      fails++;
      $display("FAIL R1 pen/stby/wake=%b%b%b expected 100", power_en, standby, wake_pulse);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (power_en !== 1'b1 || standby !== 1'b0 || wake_pulse !== 1'b0) begin
      fails++;
      $display("FAIL R1 after release pen/stby/wake=%b%b%b expected 100",
               power_en, standby, wake_pulse);
    end
    mon_on = 1'b1;

    // R2: balanced toggling
    for (int i = 0; i < 10; i++) begin hold_high(4); hold_low(4); end
    // R2: skewed duty, high exactly at the limit
    for (int i = 0; i < 5; i++) begin hold_high(LIM); hold_low(1); end
    // R3 entry one past the limit, R5/R6 single-cycle wake
    hold_high(LIM + 1);
    hold_low(1);
    hold_high(3);
    hold_low(6);
    // R4: long park, state held
    hold_high(3 * LIM);
    checks++;
    if (standby !== 1'b1 || power_en !== 1'b0) begin
      fails++;
      $display("FAIL R4 stby/pen=%b%b during long park, expected 10", standby, power_en);
    end
    hold_low(5);
    // R8: restart on a single low between two limit-long highs
    hold_high(LIM); hold_low(1); hold_high(LIM); hold_low(4);
    // R2: normal clocking after wake
    for (int i = 0; i < 6; i++) begin hold_high(3); hold_low(5); end
    repeat (10) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R3 %0d expected events missing, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule